// File: doc/BRIEF.md
# Sequencer Track Data Parser

This block sits between a host data port and the track storage of a tick-driven MIDI sequencer. The sequencer asks the host for material by placing a request code in the host's read queue. The parser watches the codes the host actually reads. A track request selects one of the track buffers. A conductor request selects the conductor buffer. An end or clock report parks the parser. The data bytes the host then writes are split into a timing byte and up to a fixed number of message bytes, and each one becomes a write strobe into the selected buffer. The first message byte also produces a type code for the entry.

Two direct-send modes bypass the buffers. A single-byte send command forwards exactly one later data byte to the MIDI output. A system-message send command forwards every data byte until the end-of-exclusive byte arrives. While a parameter command elsewhere is still waiting for its argument, data bytes belong to that command and the parser leaves them alone. Every output is registered and appears one clock after the strobe that caused it.

Top module: `seq_track_parser`

## Requirements
- R1: After reset, all write strobes, the MIDI strobe, `tgt_cond` and `tgt_trk` are 0, and the parser is idle, so data bytes written before any request has been read produce no output.
- R2: A host read of a code 0xF0–0xF7 selects track (code & 7) with `tgt_cond`=0, pulses `cnt_wr` with `cnt_val`=0 one cycle later, and puts the parser in the timing-byte state.
- R3: A host read of 0xF9 selects the conductor buffer (`tgt_cond`=1), pulses `cnt_wr` with 0 and enters the timing state. A read of 0xFC or 0xFD makes the parser idle, so later data bytes produce no output. Any other read code leaves the parser state unchanged.
- R4: In the timing state, a byte below 0xF0 is written as the counter (`cnt_wr`, `cnt_val`=byte) and the parser moves to the message state with the byte index at 0.
- R5: In the timing state, the byte 0xF8 gives, in one cycle, `cnt_wr` with 0xF8, `typ_wr` with type 1 (overflow) and `entry_done`, and the parser goes idle.
- R6: In the timing state, any byte 0xF0 or above other than 0xF8 writes 0xF8 as the counter, without `typ_wr` or `entry_done`, and the parser goes idle.
- R7: In the message state, successive bytes are written with `msg_wr` at indices 0, 1, … up to MSG_MAX−1. Bytes after that are dropped with no output.
- R8: The first message byte of an entry also pulses `typ_wr` and `entry_done`. For a track the type is 2 (mark) for 0xF8–0xFF, 3 (system) for 0xF0–0xF7, 4 (channel) for 0x80–0xEF and 5 (running data) below 0x80. For the conductor the type is always 6 (command).
- R9: A command 0xD0–0xD7 arms single-byte send. The next data byte is output on `midi_byte` with `midi_vld` one cycle later and the mode disarms. A byte 0xF0 or above while `allthru_en`=0 is not output and leaves the mode armed. Bytes taken by this mode never reach the parser.
- R10: Command 0xDF arms system-message send. Each data byte is output until 0xF7 arrives. 0xF7 ends the mode and is not output. Bytes 0xF0 or above are not output while `allthru_en`=0. Arming either send mode cancels the other.
- R11: A data byte written while `param_busy`=1 produces no output and changes neither parser nor send-mode state.
- R12: A read strobe or data strobe produces at most one output cycle, exactly one clock after the strobe. A read takes priority over a data byte in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd_vld | input | 1 | Host read a byte from the reply queue |
| host_rd_byte | input | 8 | The byte the host read |
| cmd_vld | input | 1 | Host command write strobe |
| cmd_byte | input | 8 | Command code |
| data_vld | input | 1 | Host data write strobe |
| data_byte | input | 8 | Data byte |
| param_busy | input | 1 | A parameter command is waiting for its argument |
| allthru_en | input | 1 | Allow bytes 0xF0 and above through the direct-send modes |
| tgt_cond | output | 1 | Writes target the conductor buffer |
| tgt_trk | output | TRK_W | Selected track |
| cnt_wr | output | 1 | Counter write strobe |
| cnt_val | output | 8 | Counter value |
| msg_wr | output | 1 | Message byte write strobe |
| msg_idx | output | IDX_W | Message byte index |
| msg_val | output | 8 | Message byte value |
| typ_wr | output | 1 | Entry type write strobe |
| typ_val | output | 3 | Entry type code |
| entry_done | output | 1 | Entry became valid for the sequencer |
| midi_vld | output | 1 | Direct MIDI byte strobe |
| midi_byte | output | 8 | Direct MIDI byte |

## Verification
The bench builds the block with eight tracks and eight message slots. With those values every track request code maps onto a real buffer, and a full entry followed by a ninth byte is short enough to reach the drop rule directly. The stimulus switches between the parser and the two send modes on the same selected track. This shows that bytes taken by a send mode or by a pending parameter leave the message index where it was. It also shows that a filtered byte keeps single send armed.

// File: rtl/seqp_pkg.sv
package seqp_pkg;

    typedef enum logic [2:0] {
        TY_NONE = 3'd0,
        TY_OVF  = 3'd1,
        TY_MARK = 3'd2,
        TY_SYS  = 3'd3,
        TY_CHAN = 3'd4,
        TY_DATA = 3'd5,
        TY_CMD  = 3'd6
    } msg_type_e;

    typedef enum logic [1:0] {
        PS_IDLE = 2'd0,
        PS_TIME = 2'd1,
        PS_MSG  = 2'd2
    } pstate_e;

    localparam logic [7:0] RD_COND     = 8'hF9;
    localparam logic [7:0] RD_END      = 8'hFC;
    localparam logic [7:0] RD_CLK      = 8'hFD;
    localparam logic [7:0] TM_OVF      = 8'hF8;
    localparam logic [7:0] TM_LIMIT    = 8'hF0;
    localparam logic [7:0] SYS_END     = 8'hF7;
    localparam logic [7:0] CMD_SYSSEND = 8'hDF;

    function automatic logic is_track_req(input logic [7:0] b);
        return b[7:3] == 5'b11110;
    endfunction

    function automatic logic is_single_cmd(input logic [7:0] b);
        return b[7:3] == 5'b11010;
    endfunction

endpackage

// File: rtl/seqp_classify.sv
module seqp_classify
    import seqp_pkg::*;
(
    input  logic [7:0] first_byte,
    input  logic       for_cond,
    output msg_type_e  ty
);
    always_comb begin
        if (for_cond)                ty = TY_CMD;
        else if (first_byte >= 8'hF8) ty = TY_MARK;
        else if (first_byte >= 8'hF0) ty = TY_SYS;
        else if (first_byte >= 8'h80) ty = TY_CHAN;
        else                          ty = TY_DATA;
    end
endmodule

// File: rtl/seqp_direct.sv
module seqp_direct
    import seqp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_vld,
    input  logic [7:0] cmd_byte,
    input  logic       data_vld,
    input  logic [7:0] data_byte,
    input  logic       allthru_en,
    output logic       claim,
    output logic       midi_vld,
    output logic [7:0] midi_byte
);
    logic one_armed;
    logic sys_armed;
    logic blocked;

    assign claim   = one_armed | sys_armed;
    assign blocked = (data_byte >= TM_LIMIT) && !allthru_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            one_armed <= 1'b0;
            sys_armed <= 1'b0;
            midi_vld  <= 1'b0;
            midi_byte <= 8'h00;
        end else begin
            midi_vld <= 1'b0;
            if (data_vld && one_armed) begin
                if (!blocked) begin
                    midi_vld  <= 1'b1;
                    midi_byte <= data_byte;
                    one_armed <= 1'b0;
                end
            end else if (data_vld && sys_armed) begin
                if (data_byte == SYS_END) begin
                    sys_armed <= 1'b0;
                end else if (!blocked) begin
                    midi_vld  <= 1'b1;
                    midi_byte <= data_byte;
                end
            end
            if (cmd_vld) begin
                if (is_single_cmd(cmd_byte)) begin
                    one_armed <= 1'b1;
                    sys_armed <= 1'b0;
                end else if (cmd_byte == CMD_SYSSEND) begin
                    sys_armed <= 1'b1;
                    one_armed <= 1'b0;
                end
            end
        end
    end

    assert_midi_from_data_R9: assert property (@(posedge clk) disable iff (rst)
        midi_vld |-> $past(data_vld));

    assert_sysend_held_R10: assert property (@(posedge clk) disable iff (rst)
        (midi_vld && $past(sys_armed) && !$past(one_armed)) |-> (midi_byte != SYS_END));

endmodule

// File: rtl/seqp_fill.sv
module seqp_fill
    import seqp_pkg::*;
#(
    parameter int TRK_N   = 8,
    parameter int MSG_MAX = 8,
    localparam int TRK_W  = $clog2(TRK_N),
    localparam int IDX_W  = $clog2(MSG_MAX),
    localparam int CNT_W  = $clog2(MSG_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_vld,
    input  logic [7:0]       rd_byte,
    input  logic             data_vld,
    input  logic [7:0]       data_byte,
    output logic             tgt_cond,
    output logic [TRK_W-1:0] tgt_trk,
    output logic             cnt_wr,
    output logic [7:0]       cnt_val,
    output logic             msg_wr,
    output logic [IDX_W-1:0] msg_idx,
    output logic [7:0]       msg_val,
    output logic             typ_wr,
    output logic [2:0]       typ_val,
    output logic             entry_done
);
    pstate_e          st;
    logic [CNT_W-1:0] n_msg;
    msg_type_e        cls;

    seqp_classify u_cls (
        .first_byte (data_byte),
        .for_cond   (tgt_cond),
        .ty         (cls)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= PS_IDLE;
            tgt_cond   <= 1'b0;
            tgt_trk    <= '0;
            n_msg      <= '0;
            cnt_wr     <= 1'b0;
            cnt_val    <= 8'h00;
            msg_wr     <= 1'b0;
            msg_idx    <= '0;
            msg_val    <= 8'h00;
            typ_wr     <= 1'b0;
            typ_val    <= TY_NONE;
            entry_done <= 1'b0;
        end else begin
            cnt_wr     <= 1'b0;
            msg_wr     <= 1'b0;
            typ_wr     <= 1'b0;
            entry_done <= 1'b0;
            if (rd_vld) begin
                if (is_track_req(rd_byte)) begin
                    st       <= PS_TIME;
                    tgt_cond <= 1'b0;
                    tgt_trk  <= rd_byte[TRK_W-1:0];
                    cnt_wr   <= 1'b1;
                    cnt_val  <= 8'h00;
                end else if (rd_byte == RD_COND) begin
                    st       <= PS_TIME;
                    tgt_cond <= 1'b1;
                    cnt_wr   <= 1'b1;
                    cnt_val  <= 8'h00;
                end else if (rd_byte == RD_END || rd_byte == RD_CLK) begin
                    st <= PS_IDLE;
                end
            end else if (data_vld) begin
                unique case (st)
                    PS_TIME: begin
                        n_msg  <= '0;
                        cnt_wr <= 1'b1;
                        if (data_byte < TM_LIMIT) begin
                            cnt_val <= data_byte;
                            st      <= PS_MSG;
                        end else if (data_byte == TM_OVF) begin
                            cnt_val    <= TM_OVF;
                            typ_wr     <= 1'b1;
                            typ_val    <= TY_OVF;
                            entry_done <= 1'b1;
                            st         <= PS_IDLE;
                        end else begin
                            cnt_val <= TM_OVF;
                            st      <= PS_IDLE;
                        end
                    end
                    PS_MSG: begin
                        if (n_msg < CNT_W'(MSG_MAX)) begin
                            msg_wr  <= 1'b1;
                            msg_idx <= n_msg[IDX_W-1:0];
                            msg_val <= data_byte;
                            n_msg   <= n_msg + CNT_W'(1);
                            if (n_msg == '0) begin
                                typ_wr     <= 1'b1;
                                typ_val    <= cls;
                                entry_done <= 1'b1;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assert_one_field_R12: assert property (@(posedge clk) disable iff (rst)
        !(cnt_wr && msg_wr));

    assert_read_clears_R2: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(rd_vld) && is_track_req($past(rd_byte)))
            |-> (cnt_wr && cnt_val == 8'h00 && !tgt_cond));

    assert_ovf_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (typ_wr && typ_val == TY_OVF) |-> (cnt_wr && cnt_val == TM_OVF && entry_done));

    assert_type_first_R8: assert property (@(posedge clk) disable iff (rst)
        (typ_wr && !cnt_wr) |-> (msg_wr && msg_idx == '0));

    assert_later_index_R7: assert property (@(posedge clk) disable iff (rst)
        (msg_wr && !typ_wr) |-> (msg_idx != '0));

    assert_done_typed_R8: assert property (@(posedge clk) disable iff (rst)
        entry_done |-> typ_wr);

endmodule

// File: rtl/seq_track_parser.sv
module seq_track_parser
    import seqp_pkg::*;
#(
    parameter int TRK_N   = 8,
    parameter int MSG_MAX = 8,
    localparam int TRK_W  = $clog2(TRK_N),
    localparam int IDX_W  = $clog2(MSG_MAX)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             host_rd_vld,
    input  logic [7:0]       host_rd_byte,
    input  logic             cmd_vld,
    input  logic [7:0]       cmd_byte,
    input  logic             data_vld,
    input  logic [7:0]       data_byte,
    input  logic             param_busy,
    input  logic             allthru_en,
    output logic             tgt_cond,
    output logic [TRK_W-1:0] tgt_trk,
    output logic             cnt_wr,
    output logic [7:0]       cnt_val,
    output logic             msg_wr,
    output logic [IDX_W-1:0] msg_idx,
    output logic [7:0]       msg_val,
    output logic             typ_wr,
    output logic [2:0]       typ_val,
    output logic             entry_done,
    output logic             midi_vld,
    output logic [7:0]       midi_byte
);
    logic data_ok;
    logic claim;
    logic parse_vld;

    assign data_ok   = data_vld && !param_busy;
    assign parse_vld = data_ok && !claim;

    seqp_direct u_direct (
        .clk        (clk),
        .rst        (rst),
        .cmd_vld    (cmd_vld),
        .cmd_byte   (cmd_byte),
        .data_vld   (data_ok),
        .data_byte  (data_byte),
        .allthru_en (allthru_en),
        .claim      (claim),
        .midi_vld   (midi_vld),
        .midi_byte  (midi_byte)
    );

    seqp_fill #(
        .TRK_N   (TRK_N),
        .MSG_MAX (MSG_MAX)
    ) u_fill (
        .clk        (clk),
        .rst        (rst),
        .rd_vld     (host_rd_vld),
        .rd_byte    (host_rd_byte),
        .data_vld   (parse_vld),
        .data_byte  (data_byte),
        .tgt_cond   (tgt_cond),
        .tgt_trk    (tgt_trk),
        .cnt_wr     (cnt_wr),
        .cnt_val    (cnt_val),
        .msg_wr     (msg_wr),
        .msg_idx    (msg_idx),
        .msg_val    (msg_val),
        .typ_wr     (typ_wr),
        .typ_val    (typ_val),
        .entry_done (entry_done)
    );

    assert_busy_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(data_vld && param_busy && !host_rd_vld))
            |-> !(cnt_wr || msg_wr || midi_vld));

    assert_no_split_R9: assert property (@(posedge clk) disable iff (rst)
        !(midi_vld && msg_wr));

endmodule

// File: tb/tb_seq_track_parser.sv
module tb_seq_track_parser;

    typedef logic [38:0] rec_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_rd_vld = 1'b0;
    logic [7:0] host_rd_byte = 8'h00;
    logic       cmd_vld = 1'b0;
    logic [7:0] cmd_byte = 8'h00;
    logic       data_vld = 1'b0;
    logic [7:0] data_byte = 8'h00;
    logic       param_busy = 1'b0;
    logic       allthru_en = 1'b1;
    logic       tgt_cond;
    logic [2:0] tgt_trk;
    logic       cnt_wr;
    logic [7:0] cnt_val;
    logic       msg_wr;
    logic [2:0] msg_idx;
    logic [7:0] msg_val;
    logic       typ_wr;
    logic [2:0] typ_val;
    logic       entry_done;
    logic       midi_vld;
    logic [7:0] midi_byte;

    int checks = 0;
    int errors = 0;
    bit running = 1'b0;
    bit finished = 1'b0;
    rec_t  exp_q[$];
    string req_q[$];

    always #4 clk = ~clk;

    seq_track_parser #(.TRK_N(8), .MSG_MAX(8)) dut (
        .clk(clk), .rst(rst),
        .host_rd_vld(host_rd_vld), .host_rd_byte(host_rd_byte),
        .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
        .data_vld(data_vld), .data_byte(data_byte),
        .param_busy(param_busy), .allthru_en(allthru_en),
        .tgt_cond(tgt_cond), .tgt_trk(tgt_trk),
        .cnt_wr(cnt_wr), .cnt_val(cnt_val),
        .msg_wr(msg_wr), .msg_idx(msg_idx), .msg_val(msg_val),
        .typ_wr(typ_wr), .typ_val(typ_val), .entry_done(entry_done),
        .midi_vld(midi_vld), .midi_byte(midi_byte)
    );

    localparam rec_t QUIET = '0;

    function automatic rec_t r_cnt(input logic tc, input logic [2:0] tt, input logic [7:0] v);
        return {1'b1, v, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b0, 8'h00, tc, tc ? 3'd0 : tt};
    endfunction

    function automatic rec_t r_ovf(input logic [2:0] tt);
        return {1'b1, 8'hF8, 1'b0, 3'd0, 8'h00, 1'b1, 3'd1, 1'b1, 1'b0, 8'h00, 1'b0, tt};
    endfunction

    function automatic rec_t r_msg(input logic tc, input logic [2:0] tt, input logic [2:0] idx,
                                   input logic [7:0] v, input logic tw, input logic [2:0] tv);
        return {1'b0, 8'h00, 1'b1, idx, v, tw, tw ? tv : 3'd0, tw, 1'b0, 8'h00, tc, tc ? 3'd0 : tt};
    endfunction

    function automatic rec_t r_midi(input logic [7:0] b);
        return {1'b0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 3'd0, 1'b0, 1'b1, b, 1'b0, 3'd0};
    endfunction

    task automatic put(input rec_t e, input string r);
        exp_q.push_back(e);
        req_q.push_back(r);
    endtask

    task automatic rd(input logic [7:0] b, input rec_t e, input string r);
        host_rd_vld = 1'b1; host_rd_byte = b;
        @(posedge clk); put(e, r); #1;
        host_rd_vld = 1'b0;
    endtask

    task automatic wr(input logic [7:0] b, input rec_t e, input string r);
        data_vld = 1'b1; data_byte = b;
        @(posedge clk); put(e, r); #1;
        data_vld = 1'b0;
    endtask

    task automatic wrb(input logic [7:0] b, input rec_t e, input string r);
        data_vld = 1'b1; data_byte = b; param_busy = 1'b1;
        @(posedge clk); put(e, r); #1;
        data_vld = 1'b0; param_busy = 1'b0;
    endtask

    task automatic cmd(input logic [7:0] b, input rec_t e, input string r);
        cmd_vld = 1'b1; cmd_byte = b;
        @(posedge clk); put(e, r); #1;
        cmd_vld = 1'b0;
    endtask

    // Monitor: one scoreboard entry per strobe, compared in the cycle after it
    always @(negedge clk) begin
        if (running && !rst) begin
            logic act;
            rec_t obs;
            act = cnt_wr | msg_wr | typ_wr;
            obs = {cnt_wr, cnt_wr ? cnt_val : 8'h00,
                   msg_wr, msg_wr ? msg_idx : 3'd0, msg_wr ? msg_val : 8'h00,
                   typ_wr, typ_wr ? typ_val : 3'd0, entry_done,
                   midi_vld, midi_vld ? midi_byte : 8'h00,
                   act ? tgt_cond : 1'b0, (act && !tgt_cond) ? tgt_trk : 3'd0};
            if (exp_q.size() > 0) begin
                rec_t e;
                string r;
                e = exp_q.pop_front();
                r = req_q.pop_front();
                checks++;
                if (obs !== e) begin
                    errors++;
                    $display("FAIL %s: got %h expected %h", r, obs, e);
                end
            end else if (obs != QUIET) begin
                checks++;
                errors++;
                $display("FAIL R12 unrequested output: got %h expected %h", obs, QUIET);
            end
        end
    end

    task automatic summary;
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R12 watchdog expired: got timeout expected completion");
        summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        checks++;
        if ({cnt_wr, msg_wr, typ_wr, entry_done, midi_vld, tgt_cond, tgt_trk} !== 8'h00) begin
            errors++;
            $display("FAIL R1 reset state: got %b expected 0",
                     {cnt_wr, msg_wr, typ_wr, entry_done, midi_vld, tgt_cond, tgt_trk});
        end
        running = 1'b1;
        @(posedge clk); #1;

        // R1: idle after reset, data ignored
        wr(8'h10, QUIET, "R1 idle ignores data");
        // R2 / R4 / R8 / R7: track 3 entry, full and overfull
        rd(8'hF3, r_cnt(0, 3, 8'h00), "R2 track request clears counter");
        wr(8'h20, r_cnt(0, 3, 8'h20), "R4 timing byte");
        wr(8'h90, r_msg(0, 3, 3'd0, 8'h90, 1'b1, 3'd4), "R8 channel message type");
        for (int i = 1; i < 8; i++)
            wr(8'h40 + 8'(i), r_msg(0, 3, 3'(i), 8'h40 + 8'(i), 1'b0, 3'd0), "R7 message byte index");
        wr(8'h55, QUIET, "R7 ninth byte dropped");
        // R3: end report parks the parser
        rd(8'hFC, QUIET, "R3 end read");
        wr(8'h05, QUIET, "R3 data ignored after end read");
        rd(8'hF4, r_cnt(0, 4, 8'h00), "R2 track 4 request");
        rd(8'hFD, QUIET, "R3 clock read");
        wr(8'h07, QUIET, "R3 data ignored after clock read");
        // R3 / R8: conductor entry
        rd(8'hF9, r_cnt(1, 0, 8'h00), "R3 conductor request");
        wr(8'h00, r_cnt(1, 0, 8'h00), "R4 conductor timing");
        wr(8'hE0, r_msg(1, 0, 3'd0, 8'hE0, 1'b1, 3'd6), "R8 conductor command type");
        // R5: overflow timing byte
        rd(8'hF0, r_cnt(0, 0, 8'h00), "R2 track 0 request");
        wr(8'hF8, r_ovf(3'd0), "R5 overflow entry");
        wr(8'h33, QUIET, "R5 idle after overflow");
        // R6: other high timing byte
        rd(8'hF1, r_cnt(0, 1, 8'h00), "R2 track 1 request");
        wr(8'hFA, r_cnt(0, 1, 8'hF8), "R6 bad timing byte");
        wr(8'h10, QUIET, "R6 idle after bad timing");
        // R8: remaining classes on track 2
        rd(8'hF2, r_cnt(0, 2, 8'h00), "R2 track 2 request");
        wr(8'h00, r_cnt(0, 2, 8'h00), "R4 timing");
        wr(8'hFC, r_msg(0, 2, 3'd0, 8'hFC, 1'b1, 3'd2), "R8 mark type");
        rd(8'hF2, r_cnt(0, 2, 8'h00), "R2 track 2 request");
        wr(8'h01, r_cnt(0, 2, 8'h01), "R4 timing");
        wr(8'hF2, r_msg(0, 2, 3'd0, 8'hF2, 1'b1, 3'd3), "R8 system type");
        rd(8'hF2, r_cnt(0, 2, 8'h00), "R2 track 2 request");
        wr(8'h02, r_cnt(0, 2, 8'h02), "R4 timing");
        wr(8'h45, r_msg(0, 2, 3'd0, 8'h45, 1'b1, 3'd5), "R8 running data type");
        // R3: unrelated read code leaves state alone
        rd(8'h80, QUIET, "R3 other read code");
        wr(8'h46, r_msg(0, 2, 3'd1, 8'h46, 1'b0, 3'd0), "R3 state kept after other read");
        // R11: pending parameter takes the byte
        wrb(8'h99, QUIET, "R11 busy byte ignored");
        wr(8'h47, r_msg(0, 2, 3'd2, 8'h47, 1'b0, 3'd0), "R11 index unchanged by busy byte");
        // R9: single-byte send
        cmd(8'hD5, QUIET, "R9 arm single send");
        wr(8'h91, r_midi(8'h91), "R9 single byte sent");
        wr(8'h22, r_msg(0, 2, 3'd3, 8'h22, 1'b0, 3'd0), "R9 disarmed after one byte");
        allthru_en = 1'b0;
        cmd(8'hD0, QUIET, "R9 arm single send");
        wr(8'hF5, QUIET, "R9 high byte filtered");
        wr(8'h30, r_midi(8'h30), "R9 still armed after filter");
        // R10: system message send
        allthru_en = 1'b1;
        cmd(8'hDF, QUIET, "R10 arm system send");
        wr(8'hF0, r_midi(8'hF0), "R10 byte sent");
        wr(8'h41, r_midi(8'h41), "R10 byte sent");
        wr(8'hF7, QUIET, "R10 end byte not sent");
        wr(8'h12, r_msg(0, 2, 3'd4, 8'h12, 1'b0, 3'd0), "R10 mode ended");
        allthru_en = 1'b0;
        cmd(8'hDF, QUIET, "R10 arm system send");
        wr(8'hF2, QUIET, "R10 high byte filtered");
        wr(8'h11, r_midi(8'h11), "R10 byte sent");
        wr(8'hF7, QUIET, "R10 end byte not sent");
        allthru_en = 1'b1;
        cmd(8'hD1, QUIET, "R10 arm single send");
        cmd(8'hDF, QUIET, "R10 system send cancels single");
        wr(8'h01, r_midi(8'h01), "R10 byte sent");
        wr(8'h02, r_midi(8'h02), "R10 second byte sent");
        wr(8'hF7, QUIET, "R10 end byte not sent");
        wr(8'h13, r_msg(0, 2, 3'd5, 8'h13, 1'b0, 3'd0), "R12 parser resumes");

        repeat (3) @(posedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R12 pending results: got %0d expected 0", exp_q.size());
        end
        summary();
    end

endmodule